// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Access Controller

This block sits between a synchronous host and an external pseudo-static RAM that has an asynchronous bus. The host hands over one 16-bit word request at a time through a valid/ready port. Each request carries an address, a write flag, a two-bit lane mask and write data. The controller turns the request into a single asynchronous bus cycle. It drives the active-low select, write strobe, output enable and the two byte-lane enables, along with the address and the outgoing data with its drive enable. For reads it returns the captured word together with a one-clock valid pulse.

Every bus interval is a parameter counted in system clocks: address setup, read access time, write pulse width, write data hold, the read-to-write turnaround and the recovery gap between cycles. Reads are select-controlled. The address is settled before select falls, so the select-to-data time sets the read latency. A write opens select, write strobe and the chosen lane enables on the same edge and closes them on the same edge. The write data stays driven after that edge. When the mask has no lane set, no bus cycle is started.

Top module: `psramCtrl`

## Requirements
- R1: After reset and whenever the controller is idle, select, write strobe, output enable and both lane enables are high, the data drive enable is low, and the request port is ready.
- R2: For a read, the address is presented at least SETUP_CYC clocks before select falls. Select, output enable and the mask-selected lane enables then stay low for exactly RD_ACC_CYC clocks while the write strobe stays high. The address does not change while select is low.
- R3: Read data is sampled on the last clock of the access count. Select and output enable rise on the same edge, and the response valid flag pulses for exactly one clock with the word. Writes give no response.
- R4: Mask bit 0 controls the lower lane (data bits 7:0, lower enable) and mask bit 1 controls the upper lane (bits 15:8, upper enable), in both reads and writes. On a read, an unselected lane returns zero, and on a write it leaves memory unchanged.
- R5: For a write, data is driven from the setup phase onward. Select, write strobe and the lane enables are low together for exactly WR_PULSE_CYC clocks while output enable stays high. Data is still driven on the edge that ends the write and for WR_HOLD_CYC clocks after it.
- R6: The data drive enable and output enable are never active together. A write accepted after a read raises the drive enable TURN_CYC clocks after acceptance. A write accepted after a write raises it in the acceptance clock.
- R7: A request whose mask is zero starts no bus cycle: select never falls. A zero-mask write has no effect on memory. A zero-mask read returns one response pulse with data zero.
- R8: Only one request is in flight. Ready drops after acceptance and returns after the bus cycle and RECOV_CYC recovery clocks. A read keeps it low for SETUP_CYC+RD_ACC_CYC+RECOV_CYC clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqMask | input | 2 | Lane mask: bit 0 lower byte, bit 1 upper byte |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-clock read response pulse |
| rspData | output | DATA_W | Read response word |
| memAddr | output | ADDR_W | Memory address |
| memCsN | output | 1 | Active-low select |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memUbN | output | 1 | Active-low upper lane enable |
| memLbN | output | 1 | Active-low lower lane enable |
| memDout | output | DATA_W | Data toward memory |
| memDoutEn | output | 1 | Drive enable for memDout |
| memDin | input | DATA_W | Data from memory |

## Verification
On every clock, assertions check the following: the idle bus is quiet, output enable never overlaps the write strobe or the data drive, select never falls without a lane, the address is stable under select, select and output enable rise together at the end of a read, data is still driven when a write ends, and the response pulse is single and never overlaps ready. Some behaviours can only be shown by the bench's scenarios against its memory model. These are the exact access and pulse lengths, the address setup before select, the lane merging of partial writes and reads, the zero-fill of unselected read lanes, the turnaround delay measured from acceptance, and the absence of any select edge for zero-mask requests.

// File: rtl/psramCtrlPkg.sv
package psramCtrlPkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_TURN   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_ACTIVE = 3'd3,
    PH_HOLD   = 3'd4,
    PH_RECOV  = 3'd5
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture request fields (comb)
    logic dropRd;   // zero-mask read: answer with zero (comb)
    logic capture;  // last access clock of a read (comb)
    logic csOn;     // registered bus strobes
    logic weOn;
    logic oeOn;
    logic laneOn;
    logic doutOn;
  } busStb_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psramCtrlFsm.sv
module psramCtrlFsm
  import psramCtrlPkg::*;
#(
  parameter int LANES        = 2,
  parameter int SETUP_CYC    = 1,
  parameter int RD_ACC_CYC   = 3,
  parameter int WR_PULSE_CYC = 3,
  parameter int WR_HOLD_CYC  = 1,
  parameter int TURN_CYC     = 2,
  parameter int RECOV_CYC    = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic             reqReady,
  output busStb_t          stb
);

  localparam int MAX_CYC = maxOf(maxOf(maxOf(SETUP_CYC, RD_ACC_CYC), maxOf(WR_PULSE_CYC, WR_HOLD_CYC)),
                                 maxOf(TURN_CYC, RECOV_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  phase_t           state, nxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             wrR, wrNxt;
  logic             readLast;
  logic             take, drop;
  logic             csOnR, weOnR, oeOnR, laneOnR, doutOnR;
  logic             cntDone;

  function automatic logic [CNT_W-1:0] loadOf(input phase_t p, input logic w);
    case (p)
      PH_TURN:   return CNT_W'(TURN_CYC - 1);
      PH_SETUP:  return CNT_W'(SETUP_CYC - 1);
      PH_ACTIVE: return w ? CNT_W'(WR_PULSE_CYC - 1) : CNT_W'(RD_ACC_CYC - 1);
      PH_HOLD:   return CNT_W'(WR_HOLD_CYC - 1);
      PH_RECOV:  return CNT_W'(RECOV_CYC - 1);
      default:   return '0;
    endcase
  endfunction

  assign cntDone = (cnt == '0);

  always_comb begin
    nxt   = state;
    wrNxt = wrR;
    take  = 1'b0;
    drop  = 1'b0;
    case (state)
      PH_IDLE: begin
        if (reqValid) begin
          take  = 1'b1;
          wrNxt = reqWrite;
          if (reqMask == '0) begin
            drop = ~reqWrite;
            nxt  = PH_RECOV;
          end else if (reqWrite && readLast && (TURN_CYC > 0)) begin
            nxt = PH_TURN;
          end else begin
            nxt = PH_SETUP;
          end
        end
      end
      PH_TURN:   if (cntDone) nxt = PH_SETUP;
      PH_SETUP:  if (cntDone) nxt = PH_ACTIVE;
      PH_ACTIVE: if (cntDone) nxt = wrR ? PH_HOLD : PH_RECOV;
      PH_HOLD:   if (cntDone) nxt = PH_RECOV;
      PH_RECOV:  if (cntDone) nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    if (nxt != state) cntNxt = loadOf(nxt, wrNxt);
    else if (!cntDone) cntNxt = cnt - 1'b1;
    else cntNxt = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      wrR      <= 1'b0;
      readLast <= 1'b0;
      csOnR    <= 1'b0;
      weOnR    <= 1'b0;
      oeOnR    <= 1'b0;
      laneOnR  <= 1'b0;
      doutOnR  <= 1'b0;
    end else begin
      state   <= nxt;
      cnt     <= cntNxt;
      wrR     <= wrNxt;
      csOnR   <= (nxt == PH_ACTIVE);
      laneOnR <= (nxt == PH_ACTIVE);
      weOnR   <= (nxt == PH_ACTIVE) && wrNxt;
      oeOnR   <= (nxt == PH_ACTIVE) && !wrNxt;
      doutOnR <= wrNxt && ((nxt == PH_SETUP) || (nxt == PH_ACTIVE) || (nxt == PH_HOLD));
      if (state == PH_ACTIVE && cntDone) readLast <= ~wrR;
    end
  end

  assign reqReady = (state == PH_IDLE);

  always_comb begin
    stb         = '0;
    stb.load    = take;
    stb.dropRd  = drop;
    stb.capture = (state == PH_ACTIVE) && !wrR && cntDone;
    stb.csOn    = csOnR;
    stb.weOn    = weOnR;
    stb.oeOn    = oeOnR;
    stb.laneOn  = laneOnR;
    stb.doutOn  = doutOnR;
  end

  // R1: idle phase leaves every strobe released
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_IDLE) |-> !(csOnR || weOnR || oeOnR || laneOnR || doutOnR));

  // R6: never drive data while the memory may drive
  a_r6_no_fight: assert property (@(posedge clk) disable iff (!rstN)
    !(doutOnR && oeOnR));

  // R5: write strobe and output enable are exclusive
  a_r5_we_oe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(weOnR && oeOnR));

  // R8: a new request is taken only from idle
  a_r8_single: assert property (@(posedge clk) disable iff (!rstN)
    take |=> (state != PH_IDLE));

endmodule

// File: rtl/psramCtrlDatapath.sv
module psramCtrlDatapath
  import psramCtrlPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStb_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  laneEnN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] dataR;
  logic [LANES-1:0]  maskR;
  logic              rspValidR;
  logic [LANE_W-1:0] laneData [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR     <= '0;
      dataR     <= '0;
      maskR     <= '0;
      rspValidR <= 1'b0;
    end else begin
      if (stb.load) begin
        addrR <= reqAddr;
        dataR <= reqWdata;
        maskR <= reqMask;
      end
      rspValidR <= stb.capture | stb.dropRd;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneEnN[g] = ~(stb.laneOn & maskR[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneData[g] <= '0;
      else if (stb.capture) laneData[g] <= maskR[g] ? memDin[g*LANE_W +: LANE_W] : '0;
      else if (stb.dropRd) laneData[g] <= '0;
    end

    assign rspData[g*LANE_W +: LANE_W] = laneData[g];
  end

  assign rspValid  = rspValidR;
  assign memAddr   = addrR;
  assign memDout   = dataR;
  assign memDoutEn = stb.doutOn;
  assign memCsN    = ~stb.csOn;
  assign memWeN    = ~stb.weOn;
  assign memOeN    = ~stb.oeOn;

  // R2: address frozen while select is low
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  // R3: output enable and select release on the same edge
  a_r3_cs_oe_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> $rose(memCsN));

  // R3: response lasts one clock
  a_r3_rsp_single: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R5: data still driven when the write strobe ends
  a_r5_data_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDoutEn);

  // R7: select never goes low without a lane
  a_r7_lane_with_cs: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> !(&laneEnN));

endmodule

// File: rtl/psramCtrl.sv
module psramCtrl
  import psramCtrlPkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 16,
  parameter int SETUP_CYC    = 1,
  parameter int RD_ACC_CYC   = 3,
  parameter int WR_PULSE_CYC = 3,
  parameter int WR_HOLD_CYC  = 1,
  parameter int TURN_CYC     = 2,
  parameter int RECOV_CYC    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqMask,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  busStb_t           stb;
  logic [LANES-1:0]  laneEnN;

  psramCtrlFsm #(
    .LANES(LANES), .SETUP_CYC(SETUP_CYC), .RD_ACC_CYC(RD_ACC_CYC),
    .WR_PULSE_CYC(WR_PULSE_CYC), .WR_HOLD_CYC(WR_HOLD_CYC),
    .TURN_CYC(TURN_CYC), .RECOV_CYC(RECOV_CYC)
  ) uFsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMask(reqMask), .reqReady(reqReady), .stb(stb)
  );

  psramCtrlDatapath #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqMask(reqMask),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN),
    .laneEnN(laneEnN), .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

  assign memLbN = laneEnN[0];
  assign memUbN = laneEnN[1];

  // R8: no response while a new request could be taken
  a_r8_rsp_busy: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

endmodule

// File: tb/psramCtrl_test.sv
`timescale 1ns/1ps
module psramCtrl_test;

  localparam int SETUP = 1, RDACC = 3, WRPUL = 3, WRHOLD = 1, TURN = 2, RECOV = 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqReady, rspValid;
  logic [19:0] reqAddr = '0, memAddr;
  logic [1:0]  reqMask = '0;
  logic [15:0] reqWdata = '0, rspData, memDout, memDin;
  logic memCsN, memWeN, memOeN, memUbN, memLbN, memDoutEn;

  always #10 clk = ~clk;

  psramCtrl #(.SETUP_CYC(SETUP), .RD_ACC_CYC(RDACC), .WR_PULSE_CYC(WRPUL),
              .WR_HOLD_CYC(WRHOLD), .TURN_CYC(TURN), .RECOV_CYC(RECOV)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqMask(reqMask), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr), .memCsN(memCsN),
    .memWeN(memWeN), .memOeN(memOeN), .memUbN(memUbN), .memLbN(memLbN),
    .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin));

  // memory model: unselected read lanes return junk
  logic [15:0] mem [0:255];
  wire rdOn = !memCsN && !memOeN && memWeN;
  assign memDin = rdOn ? {memUbN ? 8'hA5 : mem[memAddr[7:0]][15:8],
                          memLbN ? 8'h5A : mem[memAddr[7:0]][7:0]} : 16'hDEAD;

  int nChecks = 0, nFail = 0, cyc = 0;
  int csFalls = 0, csRun = 0, csLowLen = 0, addrAge = 0, setupSeen = 0;
  int splitRise = 0, fights = 0, rspCount = 0, doutRiseCyc = 0, acceptCyc = 0;
  logic [15:0] lastRsp = '0;
  logic endDoutOk = 1'b1;
  logic prevCsN = 1, prevOeN = 1, prevDoutEn = 0, prevAct = 0, prevUb = 1, prevLb = 1;
  logic [19:0] prevAddr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic curAct;
    if (memAddr != prevAddr) addrAge = 0; else addrAge = addrAge + 1;
    if (prevCsN && !memCsN) begin csFalls++; setupSeen = addrAge; end
    if (!memCsN) csRun++;
    if (!prevCsN && memCsN) begin csLowLen = csRun; csRun = 0; end
    if (!prevOeN && memOeN && !(!prevCsN && memCsN)) splitRise++;
    if ((!memWeN && !memOeN) || (memDoutEn && !memOeN)) fights++;
    if (!prevDoutEn && memDoutEn) doutRiseCyc = cyc;
    if (rspValid) begin rspCount++; lastRsp = rspData; end
    curAct = !memCsN && !memWeN && (!memUbN || !memLbN);
    if (prevAct && !curAct) begin
      if (!prevLb) mem[memAddr[7:0]][7:0]  = memDout[7:0];
      if (!prevUb) mem[memAddr[7:0]][15:8] = memDout[15:8];
      if (!memDoutEn) endDoutOk = 1'b0;
    end
    prevAct = curAct; prevUb = memUbN; prevLb = memLbN;
    prevCsN = memCsN; prevOeN = memOeN; prevDoutEn = memDoutEn; prevAddr = memAddr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [19:0] a, input logic [1:0] m,
                       input logic [15:0] d, output int busy);
    rspCount = 0;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqMask = m; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    acceptCyc = cyc; reqValid = 0; busy = 0;
    while (!reqReady) begin busy++; @(negedge clk); end
  endtask

  task automatic testReset;
    chk("R1 strobes idle", {memCsN, memWeN, memOeN, memUbN, memLbN}, 5'b11111);
    chk("R1 drive off", memDoutEn, 0);
    chk("R1 ready", reqReady, 1);
  endtask

  task automatic testFullWriteRead;
    int busy;
    issue(1, 20'h5, 2'b11, 16'h1234, busy);
    chk("R5 pulse length", csLowLen, WRPUL);
    chk("R5 data held at end", endDoutOk, 1);
    chk("R3 no write response", rspCount, 0);
    chk("R1 idle after write", {memCsN, memWeN, memOeN, memUbN, memLbN, memDoutEn}, 6'b111110);
    issue(0, 20'h5, 2'b11, 16'h0, busy);
    chk("R3 read data", lastRsp, 16'h1234);
    chk("R3 single pulse", rspCount, 1);
    chk("R2 access length", csLowLen, RDACC);
    chk("R2 address setup", setupSeen >= SETUP, 1);
    chk("R8 read busy", busy, SETUP + RDACC + RECOV);
  endtask

  task automatic testLanes;
    int busy;
    issue(1, 20'h5, 2'b01, 16'hFF77, busy);
    issue(0, 20'h5, 2'b11, 16'h0, busy);
    chk("R4 lower-lane write", lastRsp, 16'h1277);
    issue(0, 20'h5, 2'b10, 16'h0, busy);
    chk("R4 upper-lane read zero-fill", lastRsp, 16'h1200);
    issue(0, 20'h5, 2'b01, 16'h0, busy);
    chk("R4 lower-lane read zero-fill", lastRsp, 16'h0077);
    issue(1, 20'h5, 2'b10, 16'h9900, busy);
    issue(0, 20'h5, 2'b11, 16'h0, busy);
    chk("R4 upper-lane write", lastRsp, 16'h9977);
  endtask

  task automatic testZeroMask;
    int busy, falls;
    falls = csFalls;
    issue(1, 20'h5, 2'b00, 16'hBEEF, busy);
    chk("R7 zero write no select", csFalls, falls);
    chk("R7 zero write no response", rspCount, 0);
    issue(0, 20'h5, 2'b00, 16'h0, busy);
    chk("R7 zero read no select", csFalls, falls);
    chk("R7 zero read response", rspCount, 1);
    chk("R7 zero read data", lastRsp, 16'h0);
    issue(0, 20'h5, 2'b11, 16'h0, busy);
    chk("R7 memory untouched", lastRsp, 16'h9977);
  endtask

  task automatic testTurnaround;
    int busy;
    issue(0, 20'h7, 2'b11, 16'h0, busy);
    issue(1, 20'h9, 2'b11, 16'hCAFE, busy);
    chk("R6 turnaround after read", doutRiseCyc - acceptCyc, TURN);
    chk("R8 write busy with turn", busy, TURN + SETUP + WRPUL + WRHOLD + RECOV);
    issue(1, 20'hA, 2'b11, 16'h0BAD, busy);
    chk("R6 no turnaround after write", doutRiseCyc - acceptCyc, 0);
    chk("R8 write busy", busy, SETUP + WRPUL + WRHOLD + RECOV);
    issue(0, 20'h9, 2'b11, 16'h0, busy);
    chk("R5 written word", lastRsp, 16'hCAFE);
    chk("R6 no bus fight", fights, 0);
    chk("R3 select and enable rise together", splitRise, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFullWriteRead();
    testLanes();
    testZeroMask();
    testTurnaround();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule